// File: doc/BRIEF.md
# Masked Register-Write Breakpoint Unit

This block sits beside a processor's register write-back path and raises a break request when one chosen destination register is written with a value that fits a stored pattern. The pattern is a data word paired with a per-bit care mask. Only the bit positions whose mask bit is 1 take part in the comparison. If the mask is all zeros, the unit acts as a plain address breakpoint and fires on any value written to the chosen register.

A debug host loads the mask, the pattern, the watched register address and an enable bit through a small command port. The same port clears the sticky pending flag. The CPU can read every one of these back through a special-function-register read port. The CPU can also read and write an 8-bit transfer buffer that is shared with the debug host. The unit has two resets: an asynchronous power-on reset and a synchronous reset taken from the test-logic-reset state of the debug TAP. Both put every register back to its initial value.

Top module: `regWriteWatch`

## Requirements
- R1: After power-on reset (`rstN` low) the mask reads FFFFh, the pattern reads 0000h, the buffer reads 00h, the address/enable word reads 0000h, and both `breakPulse` and `breakPending` are 0.
- R2: A cycle with `tapReset` high restores every register to its R1 value at that clock edge, and no break is raised from a write-back in that cycle.
- R3: A write-back raises a break only when `wbValid` is 1, the enable bit is 1, and `wbAddr` equals the stored breakpoint address.
- R4: A bit where the mask is 1 must equal the pattern bit for a break, and a bit where the mask is 0 is ignored: ((wbData XOR pattern) AND mask) == 0.
- R5: With the mask all zeros, any written value at the watched address, with the unit enabled, raises a break.
- R6: `breakPulse` is high for exactly the one cycle after each qualifying write-back edge. Back-to-back qualifying write-backs give consecutive pulses.
- R7: `breakPending` sets together with the pulse and stays set until a debug write with `dbgSel`=3. If a clear and a new break fall in the same cycle, the flag stays set.
- R8: A debug write is decoded by `dbgSel` (0 = mask, 1 = pattern, 2 = address in bits [7:0] with enable in bit 8, 3 = clear pending). It takes effect for write-backs from the next clock edge on, so a write-back in the same cycle still uses the old value.
- R9: `cpuRdData` is combinational from `cpuRdSel`: 0 = mask, 1 = pattern, 2 = {7'b0, enable, address[7:0]}, 3 = {8'b0, buffer}.
- R10: A CPU buffer write (`cpuBufWrEn`) loads `cpuBufWrData` at the edge and reads back from then on. It has no effect on the mask, the pattern or the address/enable word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| tapReset | input | 1 | Synchronous reset from TAP test-logic-reset, active high |
| dbgWrEn | input | 1 | Debug command write strobe |
| dbgSel | input | 2 | Debug command target |
| dbgWrData | input | 16 | Debug command data |
| cpuBufWrEn | input | 1 | CPU write strobe for the transfer buffer |
| cpuBufWrData | input | 8 | CPU write data for the buffer |
| cpuRdSel | input | 2 | CPU read selector |
| cpuRdData | output | 16 | CPU read data |
| wbValid | input | 1 | Register write-back valid |
| wbAddr | input | 8 | Destination register address |
| wbData | input | 16 | Value being written |
| breakPulse | output | 1 | One-cycle break request |
| breakPending | output | 1 | Sticky break flag |

## Verification
A qualifying write-back is sampled at clock edge N. `breakPulse` and `breakPending` show the result after edge N, and the bench samples them at the falling edge that follows. Debug and buffer writes land at the same edge and affect write-backs from edge N+1 on. CPU reads are combinational, so they are compared in the same half cycle in which the select is applied. The bench drives inputs on the falling edge and keeps a behavioural model that advances on the rising edge. It compares all three outputs at every falling edge, which keeps each check on the exact cycle in which its result is due.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  typedef enum logic [1:0] {
    DBG_MASK  = 2'd0,
    DBG_DATA  = 2'd1,
    DBG_ADDR  = 2'd2,
    DBG_CLEAR = 2'd3
  } dbgSel_e;

  typedef enum logic [1:0] {
    RD_MASK = 2'd0,
    RD_DATA = 2'd1,
    RD_ADDR = 2'd2,
    RD_BUF  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic wipe;
    logic ldMask;
    logic ldData;
    logic ldAddr;
    logic clrPend;
    logic ldBuf;
  } strobes_t;
endpackage

// File: rtl/bkpt_ctrl.sv
module bkpt_ctrl
  import bkpt_pkg::*;
(
  input  logic       tapReset,
  input  logic       dbgWrEn,
  input  logic [1:0] dbgSel,
  input  logic       cpuBufWrEn,
  output strobes_t   strb
);
  dbgSel_e selE;
  assign selE = dbgSel_e'(dbgSel);

  always_comb begin
    strb         = '0;
    strb.wipe    = tapReset;
    if (!tapReset) begin
      strb.ldBuf = cpuBufWrEn;
      if (dbgWrEn) begin
        case (selE)
          DBG_MASK:  strb.ldMask  = 1'b1;
          DBG_DATA:  strb.ldData  = 1'b1;
          DBG_ADDR:  strb.ldAddr  = 1'b1;
          DBG_CLEAR: strb.clrPend = 1'b1;
          default:   strb.clrPend = 1'b0;
        endcase
      end
    end
  end

  // R8: one debug command reaches at most one register
  always_comb begin
    a_r8_one_target: assert ($onehot0({strb.ldMask, strb.ldData, strb.ldAddr, strb.clrPend}));
  end
endmodule

// File: rtl/bkpt_dpath.sv
module bkpt_dpath
  import bkpt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int BUF_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] dbgWrData,
  input  logic [BUF_W-1:0]  cpuBufWrData,
  input  logic [1:0]        cpuRdSel,
  input  logic              wbValid,
  input  logic [ADDR_W-1:0] wbAddr,
  input  logic [DATA_W-1:0] wbData,
  output logic              breakPulse,
  output logic              breakPending,
  output logic [DATA_W-1:0] cpuRdData
);
  localparam logic [DATA_W-1:0] MASK_INIT = '1;
  localparam int                EN_BIT    = ADDR_W;

  logic [DATA_W-1:0] maskQ, dataQ;
  logic [ADDR_W-1:0] addrQ;
  logic              enQ;
  logic [BUF_W-1:0]  bufQ;
  logic              pulseQ, pendQ;
  logic              addrHit, dataHit, hit;

  assign addrHit = wbValid && enQ && (wbAddr == addrQ);
  assign dataHit = (((wbData ^ dataQ) & maskQ) == '0);
  assign hit     = addrHit && dataHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ  <= MASK_INIT;
      dataQ  <= '0;
      addrQ  <= '0;
      enQ    <= 1'b0;
      bufQ   <= '0;
      pulseQ <= 1'b0;
      pendQ  <= 1'b0;
    end else if (strb.wipe) begin
      maskQ  <= MASK_INIT;
      dataQ  <= '0;
      addrQ  <= '0;
      enQ    <= 1'b0;
      bufQ   <= '0;
      pulseQ <= 1'b0;
      pendQ  <= 1'b0;
    end else begin
      if (strb.ldMask) maskQ <= dbgWrData;
      if (strb.ldData) dataQ <= dbgWrData;
      if (strb.ldAddr) begin
        addrQ <= dbgWrData[ADDR_W-1:0];
        enQ   <= dbgWrData[EN_BIT];
      end
      if (strb.ldBuf) bufQ <= cpuBufWrData;
      pulseQ <= hit;
      pendQ  <= hit | (pendQ & ~strb.clrPend);
    end
  end

  always_comb begin
    case (rdSel_e'(cpuRdSel))
      RD_MASK: cpuRdData = maskQ;
      RD_DATA: cpuRdData = dataQ;
      RD_ADDR: cpuRdData = DATA_W'({enQ, addrQ});
      RD_BUF:  cpuRdData = DATA_W'(bufQ);
      default: cpuRdData = '0;
    endcase
  end

  assign breakPulse   = pulseQ;
  assign breakPending = pendQ;

  // R3: a pulse needs an enabled write-back to the watched address one cycle earlier
  a_r3_pulse_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    breakPulse |-> $past(wbValid && enQ && wbAddr == addrQ));
  // R5: zero mask fires on address match alone
  a_r5_zero_mask_fires: assert property (@(posedge clk) disable iff (!rstN)
    (addrHit && maskQ == '0 && !strb.wipe) |=> breakPulse);
  // R6: every pulse is reflected in the sticky flag
  a_r6_pulse_sets_pending: assert property (@(posedge clk) disable iff (!rstN)
    breakPulse |-> breakPending);
  // R7: flag holds without a clear
  a_r7_pending_holds: assert property (@(posedge clk) disable iff (!rstN)
    (breakPending && !strb.clrPend && !strb.wipe) |=> breakPending);
  // R2: TAP reset restores the mask
  a_r2_tap_mask: assert property (@(posedge clk) disable iff (!rstN)
    strb.wipe |=> (maskQ == MASK_INIT && !enQ && !breakPending));
endmodule

// File: rtl/regWriteWatch.sv
module regWriteWatch
  import bkpt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int BUF_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tapReset,
  input  logic              dbgWrEn,
  input  logic [1:0]        dbgSel,
  input  logic [DATA_W-1:0] dbgWrData,
  input  logic              cpuBufWrEn,
  input  logic [BUF_W-1:0]  cpuBufWrData,
  input  logic [1:0]        cpuRdSel,
  output logic [DATA_W-1:0] cpuRdData,
  input  logic              wbValid,
  input  logic [ADDR_W-1:0] wbAddr,
  input  logic [DATA_W-1:0] wbData,
  output logic              breakPulse,
  output logic              breakPending
);
  strobes_t strb;

  bkpt_ctrl i_ctrl (
    .tapReset  (tapReset),
    .dbgWrEn   (dbgWrEn),
    .dbgSel    (dbgSel),
    .cpuBufWrEn(cpuBufWrEn),
    .strb      (strb)
  );

  bkpt_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BUF_W(BUF_W)) i_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .dbgWrData   (dbgWrData),
    .cpuBufWrData(cpuBufWrData),
    .cpuRdSel    (cpuRdSel),
    .wbValid     (wbValid),
    .wbAddr      (wbAddr),
    .wbData      (wbData),
    .breakPulse  (breakPulse),
    .breakPending(breakPending),
    .cpuRdData   (cpuRdData)
  );
endmodule

// File: tb/test_regWriteWatch.sv
`timescale 1ns/1ps
module test_regWriteWatch;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tapReset = 1'b0;
  logic        dbgWrEn = 1'b0;
  logic [1:0]  dbgSel = '0;
  logic [15:0] dbgWrData = '0;
  logic        cpuBufWrEn = 1'b0;
  logic [7:0]  cpuBufWrData = '0;
  logic [1:0]  cpuRdSel = '0;
  logic [15:0] cpuRdData;
  logic        wbValid = 1'b0;
  logic [7:0]  wbAddr = '0;
  logic [15:0] wbData = '0;
  logic        breakPulse, breakPending;

  int    nChk = 0;
  int    nErr = 0;
  string curReq = "R1";
  bit    done = 1'b0;

  // behavioural reference state
  logic [15:0] mMask = 16'hFFFF, mData = '0;
  logic [7:0]  mAddr = '0, mBuf = '0;
  logic        mEn = 1'b0, mPulse = 1'b0, mPend = 1'b0;

  always #5 clk = ~clk;

  regWriteWatch i_regWriteWatch (
    .clk(clk), .rstN(rstN), .tapReset(tapReset),
    .dbgWrEn(dbgWrEn), .dbgSel(dbgSel), .dbgWrData(dbgWrData),
    .cpuBufWrEn(cpuBufWrEn), .cpuBufWrData(cpuBufWrData),
    .cpuRdSel(cpuRdSel), .cpuRdData(cpuRdData),
    .wbValid(wbValid), .wbAddr(wbAddr), .wbData(wbData),
    .breakPulse(breakPulse), .breakPending(breakPending)
  );

  task automatic modelClear();
    mMask = 16'hFFFF; mData = '0; mAddr = '0; mEn = 1'b0;
    mBuf = '0; mPulse = 1'b0; mPend = 1'b0;
  endtask

  always @(posedge clk) begin
    if (!rstN || tapReset) modelClear();
    else begin
      bit fire;
      fire = wbValid && mEn && (wbAddr == mAddr);
      for (int b = 0; b < 16; b++)
        if (mMask[b] && (wbData[b] != mData[b])) fire = 1'b0;
      mPulse = fire;
      if (fire) mPend = 1'b1;
      else if (dbgWrEn && dbgSel == 2'd3) mPend = 1'b0;
      if (dbgWrEn) begin
        if (dbgSel == 2'd0) mMask = dbgWrData;
        if (dbgSel == 2'd1) mData = dbgWrData;
        if (dbgSel == 2'd2) begin mAddr = dbgWrData[7:0]; mEn = dbgWrData[8]; end
      end
      if (cpuBufWrEn) mBuf = cpuBufWrData;
    end
  end

  function automatic logic [15:0] expRead();
    case (cpuRdSel)
      2'd0:    return mMask;
      2'd1:    return mData;
      2'd2:    return {7'b0, mEn, mAddr};
      default: return {8'b0, mBuf};
    endcase
  endfunction

  task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s: actual %h expected %h", curReq, what, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("breakPulse", {15'b0, breakPulse}, {15'b0, mPulse});
    chk("breakPending", {15'b0, breakPending}, {15'b0, mPend});
    chk("cpuRdData", cpuRdData, expRead());
  endtask

  // one clock: inputs already set at a falling edge, compare at the next falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle();
    dbgWrEn = 0; cpuBufWrEn = 0; wbValid = 0; tapReset = 0;
  endtask

  task automatic dbgWrite(logic [1:0] sel, logic [15:0] val);
    idle(); dbgWrEn = 1; dbgSel = sel; dbgWrData = val; step(); idle();
  endtask

  task automatic writeBack(logic [7:0] a, logic [15:0] d);
    idle(); wbValid = 1; wbAddr = a; wbData = d; step(); idle(); step();
  endtask

  task automatic readSweep();
    for (int s = 0; s < 4; s++) begin
      cpuRdSel = 2'(s); #1; chk("read", cpuRdData, expRead());
    end
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    curReq = "R1";
    step(); rstN = 1; step();
    cpuRdSel = 2'd0; #1; chk("mask reset", cpuRdData, 16'hFFFF);
    readSweep();
    chk("pulse reset", {15'b0, breakPulse}, 16'h0);

    curReq = "R3";   // disabled: no break
    writeBack(8'h00, 16'h0000);
    dbgWrite(2'd0, 16'h0000);
    dbgWrite(2'd2, 16'h0012);       // address set, enable off
    writeBack(8'h12, 16'h1234);
    dbgWrite(2'd2, 16'h0112);       // enable on
    writeBack(8'h13, 16'h1234);     // wrong address
    idle(); wbValid = 0; wbAddr = 8'h12; step(); step();

    curReq = "R5";
    writeBack(8'h12, 16'h5A5A);
    writeBack(8'h12, 16'h0000);
    curReq = "R7";
    chk("pending sticky", {15'b0, breakPending}, 16'h1);
    dbgWrite(2'd3, 16'h0000);
    chk("pending cleared", {15'b0, breakPending}, 16'h0);

    curReq = "R4";
    dbgWrite(2'd0, 16'h00FF);
    dbgWrite(2'd1, 16'h0034);
    writeBack(8'h12, 16'hAB34);
    writeBack(8'h12, 16'hAB35);
    dbgWrite(2'd0, 16'hFFFF);
    dbgWrite(2'd1, 16'hBEEF);
    writeBack(8'h12, 16'hBEEE);
    writeBack(8'h12, 16'hBEEF);
    dbgWrite(2'd3, 16'h0000);

    curReq = "R6";   // back-to-back hits
    idle(); wbValid = 1; wbAddr = 8'h12; wbData = 16'hBEEF; step();
    chk("pulse one after", {15'b0, breakPulse}, 16'h1);
    step(); idle(); step();
    chk("pulse drops", {15'b0, breakPulse}, 16'h0);

    curReq = "R7";   // set beats simultaneous clear
    idle(); wbValid = 1; wbAddr = 8'h12; wbData = 16'hBEEF;
    dbgWrEn = 1; dbgSel = 2'd3; step(); idle(); step();
    chk("set wins", {15'b0, breakPending}, 16'h1);
    dbgWrite(2'd3, 16'h0000);

    curReq = "R8";   // same-cycle pattern change uses old pattern
    idle(); wbValid = 1; wbAddr = 8'h12; wbData = 16'h1111;
    dbgWrEn = 1; dbgSel = 2'd1; dbgWrData = 16'h1111; step();
    chk("old pattern", {15'b0, breakPulse}, 16'h0);
    idle(); wbValid = 1; step();
    chk("new pattern", {15'b0, breakPulse}, 16'h1);
    idle(); step();
    dbgWrite(2'd3, 16'h0000);

    curReq = "R10";
    idle(); cpuBufWrEn = 1; cpuBufWrData = 8'hC3; step(); idle();
    cpuRdSel = 2'd3; #1; chk("buffer", cpuRdData, 16'h00C3);
    cpuRdSel = 2'd1; #1; chk("pattern untouched", cpuRdData, 16'h1111);
    curReq = "R9";
    readSweep();

    curReq = "R2";
    writeBack(8'h12, 16'h1111);
    idle(); tapReset = 1; wbValid = 1; wbAddr = 8'h12; wbData = 16'h1111; step(); idle();
    chk("no break in wipe", {15'b0, breakPulse}, 16'h0);
    cpuRdSel = 2'd0; #1; chk("mask wipe", cpuRdData, 16'hFFFF);
    readSweep();

    curReq = "R4";   // mixed traffic
    dbgWrite(2'd2, 16'h0103);
    dbgWrite(2'd0, 16'hF00F);
    dbgWrite(2'd1, 16'h3005);
    for (int i = 0; i < 400; i++) begin
      idle();
      wbValid   = ($urandom_range(0, 3) != 0);
      wbAddr    = 8'($urandom_range(0, 5));
      wbData    = ($urandom_range(0, 1) != 0) ? (16'h3005 | 16'(16'h0FF0 & $urandom)) : 16'($urandom);
      dbgWrEn   = ($urandom_range(0, 15) == 0);
      dbgSel    = 2'($urandom_range(0, 3));
      dbgWrData = 16'($urandom) & 16'h01FF;
      cpuBufWrEn = ($urandom_range(0, 7) == 0);
      cpuBufWrData = 8'($urandom);
      cpuRdSel  = 2'($urandom_range(0, 3));
      step();
    end
    idle(); step();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      nErr++;
      $display("FAIL watchdog %s: actual timeout expected completion", curReq);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
      $finish;
    end
  end
endmodule